// File: doc/BRIEF.md
# Bit I/O Port With Pattern-Match Interrupt

A general-purpose port of sixteen pins. Each pin is an input or an output, chosen one by one. An output latch drives the pins that are outputs. Software can raise or drop any subset of latch bits in one atomic write, and the other bits keep their values. Every tristate pad is modelled as a data line `pad_o` paired with an enable line `pad_oe_o`.

Pins that are inputs pass through a two-flop synchronizer. They are then compared with a programmable pattern, but only where a care mask has ones. When the compare turns from false to true, a sticky status bit is set. That bit, gated by an enable bit, drives the interrupt request `irq_o`.

Top module: `bitio_port`

## Requirements
- R1: A write to address 0 loads the direction register. Bit value 1 makes the pin an output, so `pad_oe_o` equals the register one cycle after the write edge.
- R2: A write to address 1 ORs the one bits of `wdata_i` into the output latch shown on `pad_o`. The zero bits leave the latch unchanged.
- R3: A write to address 2 clears the latch bits where `wdata_i` has ones. The zero bits leave the latch unchanged.
- R4: The output latch changes only on writes to address 1 or 2. Writes to any other address, and idle cycles, leave `pad_o` unchanged.
- R5: A read at address 0 returns the pin state. For an output pin that is the latch bit. For an input pin it is the synchronized pad value, which shows a pad change after two rising clock edges.
- R6: The pattern is written at address 3 and the care mask at address 4. The match condition holds when `(sync_in ^ pattern) & care & ~direction` is zero, so output pins never take part in the compare.
- R7: The status bit, read as bit 0 at address 1, is set on the third rising edge after a pad change that turns the match condition from false to true. A match that simply persists does not set it again.
- R8: The status bit stays set until a write to address 6 with `wdata_i[0]`=1 clears it. It stays clear while the match condition continues to hold.
- R9: `irq_o` equals the status bit ANDed with the enable bit, which is written as bit 0 at address 5.
- R10: After reset every pin is an input, the output latch is zero, the enable bit and the status bit are zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for writes and reads |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| pad_i | input | 16 | Pad input levels |
| pad_o | output | 16 | Output latch driven to the pads |
| pad_oe_o | output | 16 | Pad output enables, 1 = drive |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en_i` and `addr_i` are always at known levels. They also assume that a write strobe lasts one cycle per access, because every latch and direction check compares the outputs with the data of the previous cycle. The stimulus drives all inputs at the falling clock edge. It holds the strobe for exactly one cycle per access and leaves the pads unchanged between compare steps, so each pattern change produces a single clean transition of the match condition.

// File: rtl/bitio_pkg.sv
package bitio_pkg;
  localparam int unsigned ADDR_W = 3;

  // write map
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SET  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CARE = 3'd4;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd6;

  // read map
  localparam logic [ADDR_W-1:0] R_PINS = 3'd0;
  localparam logic [ADDR_W-1:0] R_STAT = 3'd1;
endpackage

// File: rtl/bitio_sync.sv
module bitio_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[g] <= '0;
      else if (g == 0) stg_q[g] <= d_i;
      else             stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bitio_regs.sv
module bitio_regs
  import bitio_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  pat_o,
  output logic [WIDTH-1:0]  care_o,
  output logic              ien_o,
  output logic              stat_clr_o
);
  logic [WIDTH-1:0] dir_q, out_q, pat_q, care_q;
  logic             ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      pat_q  <= '0;
      care_q <= '0;
      ien_q  <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_DIR:   dir_q  <= wdata_i;
        A_SET:   out_q  <= out_q | wdata_i;
        A_CLR:   out_q  <= out_q & ~wdata_i;
        A_PAT:   pat_q  <= wdata_i;
        A_CARE:  care_q <= wdata_i;
        A_IEN:   ien_q  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign stat_clr_o = wr_en_i && (addr_i == A_STAT) && wdata_i[0];
  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign pat_o  = pat_q;
  assign care_o = care_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/bitio_match.sv
module bitio_match #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] pat_i,
  input  logic [WIDTH-1:0] care_i,
  input  logic             stat_clr_i,
  output logic             match_o,
  output logic             stat_o
);
  logic [WIDTH-1:0] eff_care;
  logic             match_q, stat_q, rise;

  // output pins drop out of the compare
  assign eff_care = care_i & ~dir_i;
  assign match_o  = ((sync_i ^ pat_i) & eff_care) == '0;
  assign rise     = match_o & ~match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b1; // empty care mask at reset must not fire
      stat_q  <= 1'b0;
    end else begin
      match_q <= match_o;
      if (rise)            stat_q <= 1'b1;
      else if (stat_clr_i) stat_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/bitio_port.sv
module bitio_port
  import bitio_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pad_i,
  output logic [WIDTH-1:0]  pad_o,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] dir, out, pat, care, sync_in;
  logic             ien, stat_clr, match, stat;

  bitio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (sync_in)
  );

  bitio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dir_o     (dir),
    .out_o     (out),
    .pat_o     (pat),
    .care_o    (care),
    .ien_o     (ien),
    .stat_clr_o(stat_clr)
  );

  bitio_match #(.WIDTH(WIDTH)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_in),
    .dir_i     (dir),
    .pat_i     (pat),
    .care_i    (care),
    .stat_clr_i(stat_clr),
    .match_o   (match),
    .stat_o    (stat)
  );

  logic unused_match;
  assign unused_match = match;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      R_PINS:  rdata_o = (out & dir) | (sync_in & ~dir);
      R_STAT:  rdata_o[0] = stat;
      default: ;
    endcase
  end

  assign pad_o    = out;
  assign pad_oe_o = dir;
  assign irq_o    = stat & ien;
endmodule

// File: rtl/bitio_port_chk.sv
module bitio_port_chk
  import bitio_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pad_o,
  input logic [WIDTH-1:0]  pad_oe_o,
  input logic              irq_o
);
  logic unused_rd;
  assign unused_rd = ^rdata_o;

  assert_dir_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DIR) |=> pad_oe_o == $past(wdata_i));

  assert_dir_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_DIR) |=> $stable(pad_oe_o));

  assert_set_or_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_SET) |=> pad_o == ($past(pad_o) | $past(wdata_i)));

  assert_clr_and_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CLR) |=> pad_o == ($past(pad_o) & ~$past(wdata_i)));

  assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == A_SET || addr_i == A_CLR)) |=> $stable(pad_o));

  assert_irq_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_IEN && !wdata_i[0]) |=> !irq_o);
endmodule

bind bitio_port bitio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o),
  .irq_o   (irq_o)
);

// File: tb/bitio_port_bench.sv
module bitio_port_bench;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [2:0]   addr_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o, pad_o, pad_oe_o;
  logic [W-1:0] pad_i = '0;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] m_dir = '0, m_out = '0, m_pat = '0, m_care = '0;
  logic         m_ien = 1'b0;

  always #4 clk_i = ~clk_i;

  bitio_port u_bitio_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .irq_o(irq_o)
  );

  function automatic logic [W-1:0] exp_pins(logic [W-1:0] ext);
    return (m_out & m_dir) | (ext & ~m_dir);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    case (a)
      3'd0: m_dir = d;
      3'd1: m_out = m_out | d;
      3'd2: m_out = m_out & ~d;
      3'd3: m_pat = d;
      3'd4: m_care = d;
      3'd5: m_ien = d[0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] v, ext, dat;
    void'($urandom(32'd1234));
    pad_i = 16'hA5C3;
    settle(3);
    rst_ni = 1'b1;
    settle(2);

    // R10 reset state
    chk("R10 oe", pad_oe_o, '0);
    chk("R10 out", pad_o, '0);
    chk("R10 irq", {15'd0, irq_o}, '0);
    rd(3'd1, v); chk("R10 status", v, '0);

    // R2/R3 directed: single-bit set and clear
    wr(3'd1, 16'h0001); chk("R2 single set", pad_o, 16'h0001);
    wr(3'd1, 16'h8000); chk("R2 keep others", pad_o, 16'h8001);
    wr(3'd2, 16'h0001); chk("R3 single clr", pad_o, 16'h8000);
    wr(3'd2, 16'h0000); chk("R3 zero no effect", pad_o, 16'h8000);

    // random register traffic, R1-R4 against model
    for (int i = 0; i < 60; i++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 6));
      dat = W'($urandom);
      if (a == 3'd5) dat[0] = 1'b0;
      wr(a, dat);
      chk("R1 dir", pad_oe_o, m_dir);
      chk((a == 3'd1) ? "R2 set" : (a == 3'd2) ? "R3 clr" : "R4 hold", pad_o, m_out);
    end

    // R5 pin state with mixed direction
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'hF0F0);
    wr(3'd1, 16'h3C3C);
    ext = 16'h5A5A;
    @(negedge clk_i); pad_i = ext;
    settle(1);
    rd(3'd0, v); chk("R5 one edge", v, exp_pins(16'hA5C3));
    settle(1);
    rd(3'd0, v); chk("R5 two edges", v, exp_pins(ext));

    // R6-R8 random patterns, all inputs
    wr(3'd0, 16'h0000);
    for (int i = 0; i < 10; i++) begin
      logic [W-1:0] care, pat, junk;
      care = W'($urandom) | 16'h0001;
      pat  = W'($urandom);
      junk = W'($urandom) & ~care;
      wr(3'd3, pat);
      wr(3'd4, care);
      pad_i = pat ^ 16'h0001 ^ junk;   // mismatch on bit 0
      settle(4);
      wr(3'd6, 16'h0001);
      rd(3'd1, v); chk("R8 w1c", v, '0);
      pad_i = pat ^ junk;              // match, dont-care bits scrambled
      settle(2);
      rd(3'd1, v); chk("R7 not before third edge", v, '0);
      settle(1);
      rd(3'd1, v); chk("R7 set on third edge", v, 16'h0001);
      settle(3);
      rd(3'd1, v); chk("R8 sticky", v, 16'h0001);
      wr(3'd6, 16'h0000);
      rd(3'd1, v); chk("R8 zero write no clear", v, 16'h0001);
      wr(3'd6, 16'h0001);
      settle(3);
      rd(3'd1, v); chk("R7 persisting match no reset", v, '0);
    end

    // R6 output pins excluded
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'h0008);
    pad_i = 16'h0008;
    settle(4);
    wr(3'd6, 16'h0001);
    rd(3'd1, v); chk("R6 mismatch holds", v, '0);
    wr(3'd0, 16'h0008);
    settle(2);
    rd(3'd1, v); chk("R6 output pin excluded", v, 16'h0001);

    // R9 interrupt gating
    chk("R9 masked", {15'd0, irq_o}, '0);
    wr(3'd5, 16'h0001);
    chk("R9 enabled", {15'd0, irq_o}, 16'h0001);
    wr(3'd6, 16'h0001);
    chk("R9 cleared", {15'd0, irq_o}, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule